// File: doc/BRIEF.md
# I2C Target Address Decoder

This block sits on the target side of a two-wire bus. It takes SCL and SDA lines that have already been synchronised to the system clock. It recognises bus START and STOP conditions and shifts in the address byte or bytes that follow a START. It then compares them against an address configured for either 7-bit or 10-bit operation. On a match it acknowledges by enabling an open-drain pull-down on SDA for the acknowledge clock, then raises an addressed flag together with the transfer direction. On a miss it stays silent until the bus is released by a STOP.

In 10-bit operation the first byte must carry the reserved 11110 prefix and the two top address bits, and the second byte carries the low eight address bits; both are acknowledged. After a complete 10-bit match, a repeated START followed by the prefix byte with the read bit set is acknowledged on its own and selects the target for reading. A data-byte engine downstream uses `addressed` and `readNotWrite` to take over the bus after addressing.

Top module: `i2c_target_addr_decoder`

## Requirements
- R1: `startEvt` pulses for one clock after SDA falls while SCL is high, and `stopEvt` pulses for one clock after SDA rises while SCL is high; SDA changes while SCL is low produce neither.
- R2: With `tenBitMode` low, a first byte whose bits 7..1 equal `ownAddr[6:0]` is acknowledged; bit 0 is the direction, 1 for read and 0 for write.
- R3: `sdaPullEn` is never high while address bits are on the bus; on a match it rises at the SCL falling edge that ends bit 8 and drops at the SCL falling edge that ends the acknowledge clock.
- R4: With `tenBitMode` high, a first byte of 11110, `ownAddr[9:8]`, then a 0 direction bit is acknowledged, and a second byte equal to `ownAddr[7:0]` is acknowledged too.
- R5: With `tenBitMode` high, a second byte that differs from `ownAddr[7:0]` gets no acknowledge and the target goes silent until STOP.
- R6: After any address miss, no byte is acknowledged and `addressed` stays low, including after a repeated START, until a STOP is seen.
- R7: `addressed` rises at the end of the final acknowledge clock, stays high until the next START or STOP, and `readNotWrite` then holds the direction bit of the first byte.
- R8: A repeated START while addressed or while address bits are arriving drops `addressed` and decodes a fresh first byte.
- R9: In 10-bit mode a first byte of 11110, `ownAddr[9:8]`, 1 is acknowledged alone and selects a read only if a complete 10-bit match happened earlier with no STOP or miss since; otherwise it is a miss.
- R10: After reset `sdaPullEn`, `addressed`, `readNotWrite`, `startEvt` and `stopEvt` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Synchronised SCL line level |
| sdaIn | input | 1 | Synchronised SDA line level |
| tenBitMode | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| ownAddr | input | 10 | Configured target address; bits 6..0 used in 7-bit mode |
| sdaPullEn | output | 1 | Open-drain enable, 1 pulls SDA low |
| addressed | output | 1 | Target selected by the last address phase |
| readNotWrite | output | 1 | Direction of the selected transfer, 1 = read |
| startEvt | output | 1 | One-clock pulse on START (including repeated START) |
| stopEvt | output | 1 | One-clock pulse on STOP |

## Verification
A wrong bit count or a shift on the wrong SCL edge shows as an acknowledge pull-down appearing during an address bit, or as no pull-down in the ninth clock, within the first byte after the fault. A decoder state stuck in the ignore state shows as missing acknowledges for every later matching address until reset, while a lost ignore state shows as an acknowledge after a repeated START that should have been silent. A stale 10-bit armed flag shows only on the next prefix byte with the read bit set, so the random sequences mix STOPs, repeated STARTs and misses ahead of such reads.

// File: rtl/i2c_tdec_pkg.sv
package i2c_tdec_pkg;

  localparam int BYTE_BITS = 8;
  localparam int ADDR_BITS = 10;
  localparam int SHORT_ADDR_BITS = 7;
  localparam int PREFIX_BITS = 5;
  localparam logic [PREFIX_BITS-1:0] LONG_PREFIX = 5'b11110;
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_ACK1,
    ST_SECOND,
    ST_ACK2,
    ST_SELECTED,
    ST_IGNORE
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic shiftEn;
    logic setPull;
    logic clrPull;
    logic latchDir;
  } dpStrobe_t;

  // observations from datapath to control
  typedef struct packed {
    logic                 sclFall;
    logic                 startDet;
    logic                 stopDet;
    logic                 byteFull;
    logic [BYTE_BITS-1:0] byteVal;
  } dpStatus_t;

endpackage

// File: rtl/i2c_tdec_datapath.sv
module i2c_tdec_datapath
  import i2c_tdec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  dpStrobe_t strb,
  output dpStatus_t stat,
  output logic      pullEn,
  output logic      rnw,
  output logic      startEvt,
  output logic      stopEvt
);

  logic                 sclPrev;
  logic                 sdaPrev;
  logic                 sclRise;
  logic [CNT_W-1:0]     bitCnt;
  logic [BYTE_BITS-1:0] shiftReg;

  always_comb begin
    sclRise       = sclIn & ~sclPrev;
    stat.sclFall  = ~sclIn & sclPrev;
    stat.startDet = sclIn & sclPrev & sdaPrev & ~sdaIn;
    stat.stopDet  = sclIn & sclPrev & ~sdaPrev & sdaIn;
    stat.byteFull = (bitCnt == CNT_W'(BYTE_BITS));
    stat.byteVal  = shiftReg;
  end

  // line history and bus event pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      startEvt <= 1'b0;
      stopEvt  <= 1'b0;
    end else begin
      sclPrev  <= sclIn;
      sdaPrev  <= sdaIn;
      startEvt <= stat.startDet;
      stopEvt  <= stat.stopDet;
    end
  end

  // address shifter, samples SDA on SCL rising edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (strb.clrBits) begin
      bitCnt   <= '0;
    end else if (strb.shiftEn && sclRise && !stat.byteFull) begin
      shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaIn};
      bitCnt   <= bitCnt + CNT_W'(1);
    end
  end

  // open-drain enable and direction capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pullEn <= 1'b0;
      rnw    <= 1'b0;
    end else begin
      if (strb.clrPull)      pullEn <= 1'b0;
      else if (strb.setPull) pullEn <= 1'b1;
      if (strb.latchDir)     rnw    <= shiftReg[0];
    end
  end

  // R1: each bus event is a single-cycle pulse and the two never coincide
  a_r1_start_single: assert property (@(posedge clk) disable iff (!rstN)
    startEvt |=> !startEvt);
  a_r1_stop_single: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |=> !stopEvt);
  a_r1_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(startEvt && stopEvt));

endmodule

// File: rtl/i2c_tdec_control.sv
module i2c_tdec_control
  import i2c_tdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStatus_t            stat,
  input  logic                 tenBitMode,
  input  logic [ADDR_BITS-1:0] ownAddr,
  output dpStrobe_t            strb,
  output logic                 addressed,
  output ctrlState_t           stateOut
);

  ctrlState_t state, nxtState;
  logic       armed, nxtArmed;
  logic       goSecond, nxtGoSecond;
  logic       prefixOk;
  logic       firstHit;
  logic       firstNeedsSecond;
  logic       secondHit;

  always_comb begin
    prefixOk = (stat.byteVal[BYTE_BITS-1 -: PREFIX_BITS] == LONG_PREFIX) &&
               (stat.byteVal[2:1] == ownAddr[ADDR_BITS-1 -: 2]);
    if (!tenBitMode) begin
      firstHit         = (stat.byteVal[BYTE_BITS-1:1] == ownAddr[SHORT_ADDR_BITS-1:0]);
      firstNeedsSecond = 1'b0;
    end else begin
      firstHit         = prefixOk && (!stat.byteVal[0] || armed);
      firstNeedsSecond = !stat.byteVal[0];
    end
    secondHit = (stat.byteVal == ownAddr[BYTE_BITS-1:0]);
  end

  always_comb begin
    nxtState     = state;
    nxtArmed     = armed;
    nxtGoSecond  = goSecond;
    strb         = '0;
    strb.shiftEn = (state == ST_FIRST) || (state == ST_SECOND);
    if (stat.stopDet) begin
      nxtState     = ST_IDLE;
      nxtArmed     = 1'b0;
      strb.clrPull = 1'b1;
      strb.clrBits = 1'b1;
    end else if (stat.startDet && state != ST_IGNORE) begin
      nxtState     = ST_FIRST;
      strb.clrPull = 1'b1;
      strb.clrBits = 1'b1;
    end else begin
      case (state)
        ST_FIRST: begin
          if (stat.sclFall && stat.byteFull) begin
            if (firstHit) begin
              nxtState      = ST_ACK1;
              nxtGoSecond   = firstNeedsSecond;
              strb.setPull  = 1'b1;
              strb.latchDir = 1'b1;
            end else begin
              nxtState = ST_IGNORE;
              nxtArmed = 1'b0;
            end
          end
        end
        ST_ACK1: begin
          if (stat.sclFall) begin
            strb.clrPull = 1'b1;
            strb.clrBits = 1'b1;
            nxtState     = goSecond ? ST_SECOND : ST_SELECTED;
          end
        end
        ST_SECOND: begin
          if (stat.sclFall && stat.byteFull) begin
            if (secondHit) begin
              nxtState     = ST_ACK2;
              strb.setPull = 1'b1;
            end else begin
              nxtState = ST_IGNORE;
              nxtArmed = 1'b0;
            end
          end
        end
        ST_ACK2: begin
          if (stat.sclFall) begin
            strb.clrPull = 1'b1;
            strb.clrBits = 1'b1;
            nxtState     = ST_SELECTED;
            nxtArmed     = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      armed    <= 1'b0;
      goSecond <= 1'b0;
    end else begin
      state    <= nxtState;
      armed    <= nxtArmed;
      goSecond <= nxtGoSecond;
    end
  end

  assign addressed = (state == ST_SELECTED);
  assign stateOut  = state;

  // R7: selection is only ever reached through an acknowledge clock
  a_r7_select_via_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SELECTED && $past(state) != ST_SELECTED) |->
      ($past(state) == ST_ACK1 || $past(state) == ST_ACK2));
  // R9: a STOP always disarms the 10-bit read shortcut
  a_r9_disarm_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    stat.stopDet |=> !armed);
  // R6: the ignore state is left only through a STOP
  a_r6_ignore_until_stop: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_IGNORE && state != ST_IGNORE) |-> state == ST_IDLE);

endmodule

// File: rtl/i2c_target_addr_decoder.sv
module i2c_target_addr_decoder
  import i2c_tdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 tenBitMode,
  input  logic [ADDR_BITS-1:0] ownAddr,
  output logic                 sdaPullEn,
  output logic                 addressed,
  output logic                 readNotWrite,
  output logic                 startEvt,
  output logic                 stopEvt
);

  dpStrobe_t  strb;
  dpStatus_t  stat;
  ctrlState_t ctrlState;

  i2c_tdec_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strb     (strb),
    .stat     (stat),
    .pullEn   (sdaPullEn),
    .rnw      (readNotWrite),
    .startEvt (startEvt),
    .stopEvt  (stopEvt)
  );

  i2c_tdec_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stat       (stat),
    .tenBitMode (tenBitMode),
    .ownAddr    (ownAddr),
    .strb       (strb),
    .addressed  (addressed),
    .stateOut   (ctrlState)
  );

  // R6: silent while ignoring the bus
  a_r6_silent_when_ignoring: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IGNORE) |-> !sdaPullEn);
  // R3: the pull-down never changes while SCL stays high, bar bus conditions
  a_r3_pull_steady_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && !startEvt && !stopEvt) |-> $stable(sdaPullEn));
  // R7: once selected the acknowledge is already released
  a_r7_no_pull_when_addressed: assert property (@(posedge clk) disable iff (!rstN)
    addressed |-> !sdaPullEn);
  // R7: a STOP leaves the target deselected
  a_r7_stop_deselects: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |-> !addressed);

endmodule

// File: tb/i2c_target_addr_decoder_test.sv
module i2c_target_addr_decoder_test;

  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       sdaDrv = 1'b1;
  logic       tenBitMode = 1'b0;
  logic [9:0] ownAddr = 10'h000;
  logic       sdaPullEn, addressed, readNotWrite, startEvt, stopEvt;
  logic       sdaLine;

  int checks = 0;
  int fails = 0;
  int startsIssued = 0, stopsIssued = 0;
  int startsSeen = 0, stopsSeen = 0;
  bit ignoringM = 0;
  bit armedM = 0;
  bit done = 0;

  assign sdaLine = sdaDrv & ~sdaPullEn;

  always #10 clk = ~clk;

  i2c_target_addr_decoder uut (
    .clk          (clk),
    .rstN         (rstN),
    .sclIn        (scl),
    .sdaIn        (sdaLine),
    .tenBitMode   (tenBitMode),
    .ownAddr      (ownAddr),
    .sdaPullEn    (sdaPullEn),
    .addressed    (addressed),
    .readNotWrite (readNotWrite),
    .startEvt     (startEvt),
    .stopEvt      (stopEvt)
  );

  always @(negedge clk) begin
    if (rstN && startEvt) startsSeen++;
    if (rstN && stopEvt)  stopsSeen++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic waitH();
    repeat (H) @(negedge clk);
  endtask

  // 0 = miss, 1 = ack then second byte, 2 = ack and selected
  function automatic int expFirst(input logic [7:0] b, input logic ten,
                                  input logic [9:0] own, input logic arm);
    if (!ten) return (b[7:1] == own[6:0]) ? 2 : 0;
    if (b[7:3] != 5'b11110 || b[2:1] != own[9:8]) return 0;
    if (!b[0]) return 1;
    return arm ? 2 : 0;
  endfunction

  task automatic busStart();
    scl = 0; waitH(); sdaDrv = 1; waitH(); scl = 1; waitH(); sdaDrv = 0; waitH();
    startsIssued++;
  endtask

  task automatic busStop();
    scl = 0; waitH(); sdaDrv = 0; waitH(); scl = 1; waitH(); sdaDrv = 1; waitH();
    stopsIssued++;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ackSeen, output bit pullInBits);
    pullInBits = 0;
    for (int i = 7; i >= 0; i--) begin
      scl = 0; waitH(); sdaDrv = b[i]; waitH();
      scl = 1; waitH();
      if (sdaPullEn) pullInBits = 1;
      waitH();
    end
    scl = 0; waitH(); sdaDrv = 1; waitH();
    scl = 1; waitH();
    ackSeen = !sdaLine;
    waitH();
  endtask

  task automatic lowerScl();
    scl = 0; waitH();
  endtask

  task automatic doAccess(input logic [7:0] b1, input logic [7:0] b2, input bit endStop);
    bit ack, bad;
    int e;
    string tag;
    busStart();
    e = ignoringM ? 0 : expFirst(b1, tenBitMode, ownAddr, armedM);
    tag = ignoringM ? "R6" : (tenBitMode ? (b1[0] ? "R9" : "R4") : "R2");
    sendByte(b1, ack, bad);
    chk("R3", "pull during address bits", bad, 0);
    chk(tag, "first byte ack", ack, e != 0);
    lowerScl();
    chk("R3", "pull released after ack clock", sdaPullEn, 0);
    if (e == 0) begin
      ignoringM = 1; armedM = 0;
      chk("R6", "addressed after miss", addressed, 0);
    end else if (e == 2) begin
      chk("R7", "addressed after single-byte match", addressed, 1);
      chk("R7", "direction", readNotWrite, b1[0]);
    end else begin
      chk("R8", "not yet addressed between bytes", addressed, 0);
      sendByte(b2, ack, bad);
      chk("R3", "pull during second byte bits", bad, 0);
      chk(b2 == ownAddr[7:0] ? "R4" : "R5", "second byte ack", ack, b2 == ownAddr[7:0]);
      lowerScl();
      if (b2 == ownAddr[7:0]) begin
        armedM = 1;
        chk("R7", "addressed after two-byte match", addressed, 1);
        chk("R7", "direction after two-byte match", readNotWrite, 0);
      end else begin
        ignoringM = 1; armedM = 0;
        chk("R5", "addressed after second-byte miss", addressed, 0);
      end
    end
    if (endStop) begin
      busStop();
      ignoringM = 0; armedM = 0;
      chk("R7", "addressed after STOP", addressed, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "sdaPullEn in reset", sdaPullEn, 0);
    chk("R10", "addressed in reset", addressed, 0);
    chk("R10", "readNotWrite in reset", readNotWrite, 0);
    chk("R10", "startEvt in reset", startEvt, 0);
    chk("R10", "stopEvt in reset", stopEvt, 0);
    rstN = 1;
    repeat (3) @(negedge clk);

    // directed 7-bit cases
    tenBitMode = 0; ownAddr = 10'h05A;
    doAccess({7'h5A, 1'b0}, 8'h00, 1);
    doAccess({7'h5A, 1'b1}, 8'h00, 0);
    // R8 repeated START while addressed re-decodes
    doAccess({7'h5A, 1'b0}, 8'h00, 1);
    // R6 miss, then matching address after repeated START stays silent
    doAccess({7'h11, 1'b0}, 8'h00, 0);
    doAccess({7'h5A, 1'b0}, 8'h00, 1);

    // directed 10-bit cases
    tenBitMode = 1; ownAddr = 10'h2C7;
    // R9 read prefix without prior match is a miss
    doAccess({5'b11110, 2'b10, 1'b1}, 8'h00, 1);
    // R4 full write match, then R9 read shortcut after repeated START
    doAccess({5'b11110, 2'b10, 1'b0}, 8'hC7, 0);
    doAccess({5'b11110, 2'b10, 1'b1}, 8'h00, 1);
    // R5 second byte mismatch
    doAccess({5'b11110, 2'b10, 1'b0}, 8'hC6, 0);
    doAccess({5'b11110, 2'b10, 1'b0}, 8'hC7, 1);
    // R9 shortcut disarmed by STOP
    doAccess({5'b11110, 2'b10, 1'b0}, 8'hC7, 1);
    doAccess({5'b11110, 2'b10, 1'b1}, 8'h00, 1);
    // 7-bit mode does not honour the prefix form
    tenBitMode = 0; ownAddr = 10'h2C7;
    doAccess({5'b11110, 2'b10, 1'b0}, 8'hC7, 1);

    // constrained random groups
    for (int g = 0; g < 8; g++) begin
      tenBitMode = $urandom % 2;
      ownAddr = 10'($urandom);
      for (int t = 0; t < 8; t++) begin
        logic [7:0] b1, b2;
        logic dir;
        int r;
        dir = 1'($urandom);
        r = $urandom % 4;
        case (r)
          0: b1 = {ownAddr[6:0], dir};
          1: b1 = {5'b11110, ownAddr[9:8], dir};
          2: b1 = 8'($urandom);
          default: b1 = {5'b11110, ownAddr[9:8] ^ 2'($urandom % 3 + 1), dir};
        endcase
        b2 = ($urandom % 2) ? ownAddr[7:0] : 8'($urandom);
        doAccess(b1, b2, (($urandom % 3) != 0) || (t == 7));
      end
    end

    repeat (4) @(negedge clk);
    chk("R1", "START pulses", startsSeen, startsIssued);
    chk("R1", "STOP pulses", stopsSeen, stopsIssued);
    done = 1;
    finishRun();
  end

endmodule